// File: doc/BRIEF.md
# PLL Coefficient Change Sequencer

This block moves a phase-locked loop from one set of divider coefficients (input divider M, feedback multiplier N, post divider PL) to another without glitching the clock it feeds. It drives the loop's control pins: enable, power-down, lock-detector power, bypass select, an output halving divider, the coefficient fields, and the slowdown and dynamic-ramp controls used to glide N. It samples the loop's lock and ramp-complete indications. All microsecond waits come from a prescaler of the system clock set through the `us_prescale` input.

A program request carries a new M, N and PL and a glide-permission flag. If gliding is allowed, the loop is running, and only N differs, N is glided and nothing else moves. Otherwise N is first glided down to a floor that keeps the oscillator at its minimum frequency. The loop then passes through bypass with a halved output, is powered up if needed, disabled, rewritten, re-enabled and relocked, and N is glided up to its target. If any glide fails during a program request, the whole request is repeated once without gliding. A disable request glides to the floor, selects bypass and turns the loop off.

States: IDLE (accept), DECIDE (choose the path), RCHK (skip a glide to the current N), RSETUP (load step constants, slowdown on), RLOAD (write N), RGO (ramp on), RPOLL (poll ramp-complete), DIV2, BYP, IDDQ, IDDQ_WAIT, OFF, COEF, ON, LCKDET, LOCK_POLL, VCO, DIV_WAIT, DIV1, DIS, DIS_BYP, DIS_OFF, DONE. Transitions: a glide that finishes or times out returns by phase. N-only and final glides go to DONE. The pre-reprogram glide goes to DIV2. The disable glide goes to DIS_BYP. A timeout on a program glide goes back to DECIDE with gliding off.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset: enable 0, power-down 1, lock-detect power 0, bypass 1, halving 0, slowdown 0, ramp 0, busy 0, error code 0, step constants 0, coefficients M=1, N=0, PL=0.
- R2: A glide is done in this order: step constants 0x2B and 0x0B loaded together with slowdown on, then N written, then ramp on. Ramp is never on without slowdown. N changes while the loop stays enabled only during slowdown.
- R3: While gliding, ramp-complete is sampled once every microsecond for at most 500 tries. On a timeout the ramp is on for exactly 500 × (us_prescale+1) cycles. Slowdown and ramp are then both cleared, and error code 1 is reported.
- R4: A request whose target N equals the current N, with M and PL unchanged on a running loop and gliding allowed, changes no output except busy.
- R5: The N floor is ceil(M × VCO_MIN_KHZ / REF_KHZ). Before a reprogram it uses the current M; in the coefficient write it uses the new M.
- R6: A full reprogram runs halving on, bypass on, power-down off (then 2 µs) only if it was set, enable off, M/N/PL written in one cycle, enable on. M and PL change only while disabled and in bypass.
- R7: Lock-detect power is turned on after enable. Lock is sampled every 2 µs for at most 251 tries. Exhausting the tries ends the request with error code 2, leaving busy high for 251 × 2 × (us_prescale+1) + 2 cycles after enable rises.
- R8: After lock, bypass is released while halving is still on. Halving is cleared 2 µs later, and N is then glided to its target.
- R9: Disable glides N to the floor if gliding is allowed and the loop is enabled, then selects bypass, then clears enable. A glide timeout is reported as code 1 but does not stop the sequence.
- R10: If a glide fails during a program request, the request is repeated once as a full reprogram without gliding.
- R11: Requests arriving while busy is high are ignored.
- R12: With gliding off, the coefficient write uses the target N directly and no glide follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_prescale | input | PS_W | System cycles per microsecond minus one |
| req_prog | input | 1 | Program request (sampled when idle, wins over disable) |
| req_dis | input | 1 | Disable request |
| allow_glide | input | 1 | Gliding of N allowed for this request |
| new_m | input | M_W | Requested input divider |
| new_n | input | N_W | Requested feedback multiplier |
| new_pl | input | PL_W | Requested post divider code |
| pll_lock | input | 1 | Loop locked |
| ramp_done | input | 1 | Dynamic ramp complete |
| pll_en | output | 1 | Loop enable |
| pll_iddq | output | 1 | Loop power-down |
| lckdet_en | output | 1 | Lock detector power |
| sel_bypass | output | 1 | Output taken from the reference instead of the oscillator |
| out_div2 | output | 1 | Output halving divider on |
| coef_m | output | M_W | Input divider field |
| coef_n | output | N_W | Feedback multiplier field |
| coef_pl | output | PL_W | Post divider field |
| slowdown | output | 1 | Slowdown mode |
| dynramp_en | output | 1 | Dynamic ramp request |
| step_a | output | 8 | First glide step constant |
| step_b | output | 8 | Second glide step constant |
| busy | output | 1 | Request in progress |
| err_code | output | 2 | 0 none, 1 glide timeout, 2 lock failure |

## Verification
The assertions assume that `pll_lock` and `ramp_done` are already synchronous to `clk`. They also assume that the loop's coefficients are changed by nothing but this block. The stimulus meets this by modelling the loop in the bench. Ramp-complete is raised only after the ramp has been on for a few cycles. Lock is raised only after enable and lock-detect power have both been on for a few cycles, and it drops when enable drops. Requests are driven on falling edges and held for one cycle.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [4:0] {
        S_IDLE, S_DECIDE, S_RCHK, S_RSETUP, S_RLOAD, S_RGO, S_RPOLL,
        S_DIV2, S_BYP, S_IDDQ, S_IDDQ_WAIT, S_OFF, S_COEF, S_ON,
        S_LCKDET, S_LOCK_POLL, S_VCO, S_DIV_WAIT, S_DIV1,
        S_DIS, S_DIS_BYP, S_DIS_OFF, S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_ONLY, PH_DOWN, PH_UP, PH_DISDN
    } glide_phase_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_RAMP = 2'd1,
        ERR_LOCK = 2'd2
    } seq_err_e;

    localparam logic [7:0] STEP_A_VAL = 8'h2B;
    localparam logic [7:0] STEP_B_VAL = 8'h0B;

    // Where a glide returns to, by phase and outcome.
    function automatic seq_state_e glide_exit(glide_phase_e ph, logic ok);
        seq_state_e nx;
        unique case (ph)
            PH_ONLY:  nx = ok ? S_DONE : S_DECIDE;
            PH_DOWN:  nx = ok ? S_DIV2 : S_DECIDE;
            PH_UP:    nx = ok ? S_DONE : S_DECIDE;
            PH_DISDN: nx = S_DIS_BYP;
            default:  nx = S_DONE;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/pll_us_tick.sv
module pll_us_tick #(
    parameter int PS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [PS_W-1:0] prescale,
    output logic            tick,
    output logic            tick2
);
    logic [PS_W-1:0] cnt;
    logic            half;

    assign tick  = !clr && (cnt == prescale);
    assign tick2 = tick && half;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt  <= '0;
            half <= 1'b0;
        end else if (tick) begin
            cnt  <= '0;
            half <= !half;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pll_nfloor.sv
module pll_nfloor #(
    parameter int M_W         = 8,
    parameter int N_W         = 12,
    parameter int REF_KHZ     = 12000,
    parameter int VCO_MIN_KHZ = 1000000
) (
    input  logic [M_W-1:0] m,
    output logic [N_W-1:0] n_low
);
    localparam logic [47:0] N_MAX = (48'd1 << N_W) - 48'd1;
    logic [47:0] prod;
    logic [47:0] quo;

    always_comb begin
        prod  = 48'(m) * 48'(VCO_MIN_KHZ) + 48'(REF_KHZ - 1);
        quo   = prod / 48'(REF_KHZ);
        n_low = (quo > N_MAX) ? N_MAX[N_W-1:0] : quo[N_W-1:0];
    end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int M_W         = 8,
    parameter int N_W         = 12,
    parameter int PL_W        = 6,
    parameter int PS_W        = 8,
    parameter int REF_KHZ     = 12000,
    parameter int VCO_MIN_KHZ = 1000000,
    parameter int POLL_BUDGET = 500
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PS_W-1:0] us_prescale,
    input  logic            req_prog,
    input  logic            req_dis,
    input  logic            allow_glide,
    input  logic [M_W-1:0]  new_m,
    input  logic [N_W-1:0]  new_n,
    input  logic [PL_W-1:0] new_pl,
    input  logic            pll_lock,
    input  logic            ramp_done,
    output logic            pll_en,
    output logic            pll_iddq,
    output logic            lckdet_en,
    output logic            sel_bypass,
    output logic            out_div2,
    output logic [M_W-1:0]  coef_m,
    output logic [N_W-1:0]  coef_n,
    output logic [PL_W-1:0] coef_pl,
    output logic            slowdown,
    output logic            dynramp_en,
    output logic [7:0]      step_a,
    output logic [7:0]      step_b,
    output logic            busy,
    output logic [1:0]      err_code
);
    localparam int RAMP_TRIES = POLL_BUDGET;
    localparam int LOCK_TRIES = POLL_BUDGET / 2 + 1;
    localparam int TRY_MAX    = (RAMP_TRIES > LOCK_TRIES) ? RAMP_TRIES : LOCK_TRIES;
    localparam int TRY_W      = $clog2(TRY_MAX + 1);
    localparam logic [TRY_W-1:0] RAMP_LAST = TRY_W'(RAMP_TRIES - 1);
    localparam logic [TRY_W-1:0] LOCK_LAST = TRY_W'(LOCK_TRIES - 1);

    seq_state_e     state, state_nx;
    glide_phase_e   phase;
    logic [N_W-1:0] tgt_n;
    logic [M_W-1:0] req_m;
    logic [N_W-1:0] req_n;
    logic [PL_W-1:0] req_pl;
    logic           glide_r;
    logic [TRY_W-1:0] tries;
    logic [N_W-1:0] nlo_cur, nlo_new;
    logic           tick, tick2, tmr_clr;
    logic           ramp_last, lock_last;

    pll_us_tick #(.PS_W(PS_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .prescale(us_prescale),
        .tick(tick), .tick2(tick2)
    );

    pll_nfloor #(.M_W(M_W), .N_W(N_W), .REF_KHZ(REF_KHZ), .VCO_MIN_KHZ(VCO_MIN_KHZ))
        u_floor_cur (.m(coef_m), .n_low(nlo_cur));

    pll_nfloor #(.M_W(M_W), .N_W(N_W), .REF_KHZ(REF_KHZ), .VCO_MIN_KHZ(VCO_MIN_KHZ))
        u_floor_new (.m(req_m), .n_low(nlo_new));

    assign tmr_clr   = !(state inside {S_RPOLL, S_IDDQ_WAIT, S_LOCK_POLL, S_DIV_WAIT});
    assign ramp_last = (tries == RAMP_LAST);
    assign lock_last = (tries == LOCK_LAST);

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:      if (req_prog) state_nx = S_DECIDE;
                         else if (req_dis) state_nx = S_DIS;
            S_DECIDE:    state_nx = (glide_r && pll_en) ? S_RCHK : S_DIV2;
            S_RCHK:      state_nx = (tgt_n == coef_n) ? glide_exit(phase, 1'b1) : S_RSETUP;
            S_RSETUP:    state_nx = S_RLOAD;
            S_RLOAD:     state_nx = S_RGO;
            S_RGO:       state_nx = S_RPOLL;
            S_RPOLL:     if (tick && ramp_done) state_nx = glide_exit(phase, 1'b1);
                         else if (tick && ramp_last) state_nx = glide_exit(phase, 1'b0);
            S_DIV2:      state_nx = S_BYP;
            S_BYP:       state_nx = S_IDDQ;
            S_IDDQ:      state_nx = pll_iddq ? S_IDDQ_WAIT : S_OFF;
            S_IDDQ_WAIT: if (tick2) state_nx = S_OFF;
            S_OFF:       state_nx = S_COEF;
            S_COEF:      state_nx = S_ON;
            S_ON:        state_nx = S_LCKDET;
            S_LCKDET:    state_nx = S_LOCK_POLL;
            S_LOCK_POLL: if (tick2 && pll_lock) state_nx = S_VCO;
                         else if (tick2 && lock_last) state_nx = S_DONE;
            S_VCO:       state_nx = S_DIV_WAIT;
            S_DIV_WAIT:  if (tick2) state_nx = S_DIV1;
            S_DIV1:      state_nx = S_RCHK;
            S_DIS:       state_nx = (glide_r && pll_en) ? S_RCHK : S_DIS_BYP;
            S_DIS_BYP:   state_nx = S_DIS_OFF;
            S_DIS_OFF:   state_nx = S_DONE;
            S_DONE:      state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pll_en     <= 1'b0;
            pll_iddq   <= 1'b1;
            lckdet_en  <= 1'b0;
            sel_bypass <= 1'b1;
            out_div2   <= 1'b0;
            coef_m     <= M_W'(1);
            coef_n     <= '0;
            coef_pl    <= '0;
            slowdown   <= 1'b0;
            dynramp_en <= 1'b0;
            step_a     <= '0;
            step_b     <= '0;
            busy       <= 1'b0;
            err_code   <= ERR_NONE;
            phase      <= PH_ONLY;
            tgt_n      <= '0;
            req_m      <= M_W'(1);
            req_n      <= '0;
            req_pl     <= '0;
            glide_r    <= 1'b0;
            tries      <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (req_prog || req_dis) begin
                    busy     <= 1'b1;
                    err_code <= ERR_NONE;
                    req_m    <= new_m;
                    req_n    <= new_n;
                    req_pl   <= new_pl;
                    glide_r  <= allow_glide;
                end
                S_DECIDE: if (glide_r && pll_en) begin
                    if (req_m == coef_m && req_pl == coef_pl) begin
                        tgt_n <= req_n;
                        phase <= PH_ONLY;
                    end else begin
                        tgt_n <= nlo_cur;
                        phase <= PH_DOWN;
                    end
                end
                S_RSETUP: begin
                    step_a   <= STEP_A_VAL;
                    step_b   <= STEP_B_VAL;
                    slowdown <= 1'b1;
                end
                S_RLOAD: coef_n <= tgt_n;
                S_RGO: begin
                    dynramp_en <= 1'b1;
                    tries      <= '0;
                end
                S_RPOLL: if (tick) begin
                    if (ramp_done) begin
                        slowdown   <= 1'b0;
                        dynramp_en <= 1'b0;
                    end else if (ramp_last) begin
                        slowdown   <= 1'b0;
                        dynramp_en <= 1'b0;
                        err_code   <= ERR_RAMP;
                        if (phase != PH_DISDN) glide_r <= 1'b0;
                    end else begin
                        tries <= tries + 1'b1;
                    end
                end
                S_DIV2:   out_div2   <= 1'b1;
                S_BYP:    sel_bypass <= 1'b1;
                S_IDDQ:   pll_iddq   <= 1'b0;
                S_OFF:    pll_en     <= 1'b0;
                S_COEF: begin
                    coef_m  <= req_m;
                    coef_pl <= req_pl;
                    coef_n  <= glide_r ? nlo_new : req_n;
                end
                S_ON:     pll_en <= 1'b1;
                S_LCKDET: begin
                    lckdet_en <= 1'b1;
                    tries     <= '0;
                end
                S_LOCK_POLL: if (tick2 && !pll_lock) begin
                    if (lock_last) err_code <= ERR_LOCK;
                    else           tries    <= tries + 1'b1;
                end
                S_VCO: sel_bypass <= 1'b0;
                S_DIV1: begin
                    out_div2 <= 1'b0;
                    tgt_n    <= req_n;
                    phase    <= PH_UP;
                end
                S_DIS: if (glide_r && pll_en) begin
                    tgt_n <= nlo_cur;
                    phase <= PH_DISDN;
                end
                S_DIS_BYP: sel_bypass <= 1'b1;
                S_DIS_OFF: pll_en     <= 1'b0;
                S_DONE:    busy       <= 1'b0;
                default: ;
            endcase
        end
    end

    // Ramp request only inside slowdown (R2)
    p_ramp_in_slow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dynramp_en |-> slowdown);

    // N moves on a live loop only while gliding (R2)
    p_n_glide_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(coef_n) && pll_en && $past(pll_en)) |-> slowdown);

    // M and PL rewritten only while off and bypassed (R6)
    p_coef_safe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(coef_m) || !$stable(coef_pl)) |-> (!pll_en && sel_bypass));

    // Enable comes up only behind bypass (R6)
    p_en_under_byp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_en) |-> sel_bypass);

    // Leaving bypass happens with the output halved and the loop on (R8)
    p_vco_halved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_bypass) |-> (pll_en && out_div2));

endmodule

// File: tb/pll_reprog_seq_bench.sv
module pll_reprog_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PS         = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  us_prescale = 8'(PS);
    logic        req_prog = 1'b0, req_dis = 1'b0, allow_glide = 1'b0;
    logic [7:0]  new_m = 8'd1;
    logic [11:0] new_n = '0;
    logic [5:0]  new_pl = '0;
    logic        pll_lock = 1'b0, ramp_done = 1'b0;
    logic        pll_en, pll_iddq, lckdet_en, sel_bypass, out_div2, slowdown, dynramp_en, busy;
    logic [7:0]  coef_m, step_a, step_b;
    logic [11:0] coef_n;
    logic [5:0]  coef_pl;
    logic [1:0]  err_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_reprog_seq u_pll_reprog_seq (
        .clk(clk), .rst_n(rst_n), .us_prescale(us_prescale),
        .req_prog(req_prog), .req_dis(req_dis), .allow_glide(allow_glide),
        .new_m(new_m), .new_n(new_n), .new_pl(new_pl),
        .pll_lock(pll_lock), .ramp_done(ramp_done),
        .pll_en(pll_en), .pll_iddq(pll_iddq), .lckdet_en(lckdet_en),
        .sel_bypass(sel_bypass), .out_div2(out_div2),
        .coef_m(coef_m), .coef_n(coef_n), .coef_pl(coef_pl),
        .slowdown(slowdown), .dynramp_en(dynramp_en),
        .step_a(step_a), .step_b(step_b), .busy(busy), .err_code(err_code)
    );

    int checks = 0, fails = 0;
    string cur_tag = "R1";

    // Loop model driving lock and ramp-complete
    int  rd_never = 0, lk_never = 0;
    int  rcnt = 0, lcnt = 0, dyn_cyc = 0, enb_cyc = 0;
    always @(negedge clk) begin
        rcnt = dynramp_en ? rcnt + 1 : 0;
        lcnt = (pll_en && lckdet_en && !pll_iddq) ? lcnt + 1 : 0;
        ramp_done = (rd_never == 0) && dynramp_en && (rcnt >= 3);
        pll_lock  = (lk_never == 0) && (lcnt >= 5);
        if (dynramp_en) dyn_cyc++;
        if (busy && pll_en) enb_cyc++;
    end

    // Reference model: ordered trace of output vectors
    logic [33:0] exp_q[$];
    int  idx = 0, trk = 0;
    bit  mb, me, mi = 1, ml, mby = 1, md, ms, mr;
    int  mm = 1, mn = 0, mp = 0, merr = 0;

    function automatic logic [33:0] act_vec();
        return {busy, pll_en, pll_iddq, lckdet_en, sel_bypass, out_div2,
                slowdown, dynramp_en, coef_m, coef_n, coef_pl};
    endfunction

    function automatic logic [33:0] mdl_vec();
        return {mb, me, mi, ml, mby, md, ms, mr, 8'(mm), 12'(mn), 6'(mp)};
    endfunction

    function automatic int nfloor(int m);
        return (m * 1000000 + 11999) / 12000;
    endfunction

    task automatic mpush();
        logic [33:0] v = mdl_vec();
        if (exp_q.size() == 0 || exp_q[$] != v) exp_q.push_back(v);
    endtask

    task automatic mglide(int tgt, output bit ok);
        ok = 1'b1;
        if (tgt == mn) return;
        ms = 1; mpush();
        mn = tgt; mpush();
        mr = 1; mpush();
        ok = (rd_never == 0);
        ms = 0; mr = 0; mpush();
        if (!ok && merr < 1) merr = 1;
    endtask

    task automatic model_prog(int m, int n, int pl, bit g);
        bit ok, fin = 0;
        mb = 1; merr = 0; mpush();
        while (!fin) begin
            if (g && me && m == mm && pl == mp) begin
                mglide(n, ok);
                if (ok) fin = 1; else g = 0;
                continue;
            end
            if (g && me) begin
                mglide(nfloor(mm), ok);
                if (!ok) begin g = 0; continue; end
            end
            md = 1; mpush();
            mby = 1; mpush();
            mi = 0; mpush();
            me = 0; mpush();
            mm = m; mp = pl; mn = g ? nfloor(m) : n; mpush();
            me = 1; mpush();
            ml = 1; mpush();
            if (lk_never != 0) begin merr = 2; fin = 1; continue; end
            mby = 0; mpush();
            md = 0; mpush();
            mglide(n, ok);
            if (ok) fin = 1; else g = 0;
        end
        mb = 0; mpush();
    endtask

    task automatic model_dis(bit g);
        bit ok;
        mb = 1; merr = 0; mpush();
        if (g && me) mglide(nfloor(mm), ok);
        mby = 1; mpush();
        me = 0; mpush();
        mb = 0; mpush();
    endtask

    // Per-clock comparison against the trace
    always @(negedge clk) begin
        if (trk != 0) begin
            logic [33:0] v;
            v = act_vec();
            checks++;
            if (v == exp_q[idx]) begin
            end else if (idx + 1 < exp_q.size() && v == exp_q[idx+1]) begin
                idx++;
            end else begin
                fails++;
                $display("FAIL %s trace step %0d: actual=%h expected=%h", cur_tag, idx, v, exp_q[idx]);
                trk = 0;
            end
        end
    end

    task automatic check(bit cond, string tag, int act, int expv);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic run_req(bit dis, int m, int n, int pl, bit g, bit poke, string tag);
        cur_tag = tag;
        exp_q.delete();
        mpush();
        if (dis) model_dis(g); else model_prog(m, n, pl, g);
        idx = 0; dyn_cyc = 0; enb_cyc = 0;
        trk = 1;
        req_prog = !dis; req_dis = dis; allow_glide = g;
        new_m = 8'(m); new_n = 12'(n); new_pl = 6'(pl);
        @(negedge clk);
        req_prog = 0; req_dis = 0;
        if (poke) begin
            repeat (5) @(negedge clk);
            // R11: a request while busy must be ignored
            req_prog = 1; allow_glide = 0; new_m = 8'd3; new_n = 12'd50; new_pl = 6'd1;
            @(negedge clk);
            req_prog = 0;
        end
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
        check(trk != 0 && idx == exp_q.size() - 1, {tag, " trace complete"}, idx, exp_q.size() - 1);
        trk = 0;
        check(err_code == 2'(merr), {tag, " error code"}, err_code, merr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        check(act_vec() == mdl_vec(), "R1 reset outputs", 0, 0);
        check(err_code == 2'd0 && step_a == 8'd0 && step_b == 8'd0, "R1 reset err/steps", err_code, 0);

        // R6 R7 R8 R5: first program from an idle loop, floor written then glide up
        run_req(0, 1, 150, 2, 1, 0, "R6_R7_R8_R5_first");
        check(step_a == 8'h2B, "R2 step A", step_a, 8'h2B);
        check(step_b == 8'h0B, "R2 step B", step_b, 8'h0B);
        check(coef_n == 12'd150, "R8 final N", coef_n, 150);

        // R4: same target, nothing moves
        run_req(0, 1, 150, 2, 1, 0, "R4_same");

        // R2: N-only glide
        run_req(0, 1, 120, 2, 1, 0, "R2_n_only");

        // R5: M changes: glide to floor of current M, rewrite with floor of new M
        run_req(0, 2, 200, 2, 1, 0, "R5_m_change");

        // R12: gliding off, target N written directly
        run_req(0, 2, 180, 3, 0, 0, "R12_no_glide");
        check(coef_n == 12'd180 && coef_pl == 6'd3, "R12 coefficients", coef_n, 180);

        // R3 R10: glide timeout, then one full retry without gliding
        rd_never = 1;
        run_req(0, 2, 190, 3, 1, 0, "R3_R10_timeout_retry");
        check(dyn_cyc == 500 * (PS + 1), "R3 ramp window", dyn_cyc, 500 * (PS + 1));
        rd_never = 0;

        // R9 R11: disable with glide, extra request while busy
        run_req(1, 0, 0, 0, 1, 1, "R9_R11_disable");
        check(!pll_en && sel_bypass && coef_n == 12'd167, "R9 disabled at floor", coef_n, 167);
        check(!busy, "R11 no second request", busy, 0);

        // R7: lock never arrives
        lk_never = 1;
        run_req(0, 1, 100, 1, 1, 0, "R7_lock_fail");
        check(enb_cyc == 251 * 2 * (PS + 1) + 2, "R7 lock window", enb_cyc, 251 * 2 * (PS + 1) + 2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule